// File: doc/BRIEF.md
# Sixteen-Bit Shift-Register Random Source and CRC16 Engine

This block holds one 16-bit linear feedback shift register that does two jobs. It produces pseudo-random values for a processor to read, and it accumulates a CRC16 over bytes the processor writes. The feedback polynomial is x^16 + x^15 + x^2 + 1. A processor reaches the block over a small byte-wide register bus with three registers: a low data byte, a high data byte and a 2-bit control field.

Writing the low byte seeds the register by shifting. Two such writes load a full 16-bit seed. Writing the high byte folds that byte into the CRC, most significant bit first, and all eight steps complete in a single clock, so the processor can write one byte every cycle. Writing 01 to the control field requests a 13-step advance with zero input, and the field returns to 00 by itself afterwards. Writing 11 to the control field switches the generator off.

The control field is the state of a four-state machine:
- CTL_IDLE (00) holds the register.
- CTL_STEP (01) means a random advance is pending.
- CTL_RSVD (10) behaves like CTL_IDLE.
- CTL_OFF (11) blocks every update except seeding.

The transitions are:
- ctrl_load: any state moves to the written value when the control field is written.
- step_done: CTL_STEP moves to CTL_IDLE when the advance fires.
- step_wait: CTL_STEP stays in CTL_STEP during a cycle with a data-register write, so the advance is deferred.
- hold: every other cycle keeps the current state.

Top module: `lfsr_crc_unit`

## Requirements
- R1: After reset the 16-bit register reads 0x0000 and the control field reads 00.
- R2: A read with address 0 returns register bits 7:0. Address 1 returns bits 15:8. Address 2 returns the control field in bits 1:0, with zeros above. Address 3 returns 0x00. Read data is combinational from the address.
- R3: A write to address 0 moves the old bits 7:0 into bits 15:8 and puts the written byte in bits 7:0, on the next clock edge. This applies in every control mode.
- R4: A write to address 1, when the mode is not 11, updates the register on the next edge by eight single steps. Byte bits 7 down to 0 are taken in that order. One step is fb = s[15] XOR bit; s = {s[14:0],0} XOR (fb ? 0x8005 : 0). Writes in consecutive cycles are each absorbed.
- R5: From seed 0xFFFF, the bytes 0x03, 0x41, 0x42, 0x43 written to address 1 leave the register at 0xB4BC.
- R6: A write of 01 to address 2 (the control field) makes the following edge apply 13 steps with zero input bits. On that same edge the control field returns to 00.
- R7: While the control field is 11, writes to address 1 and idle cycles leave the register unchanged. Seeding through address 0 still works.
- R8: With the control field at 00 or 10 and no data write, the register keeps its value.
- R9: If a 13-step advance is pending in a cycle that writes address 0 or address 1, only the write is applied and the field stays 01. The advance happens on the next cycle with no data write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_wr | input | 1 | Write strobe for one cycle |
| bus_addr | input | 2 | Register address: 0 low byte, 1 high byte, 2 control field |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data selected by bus_addr |

## Verification
The hardest situation to reach is a pending random advance colliding with a data write. The control field has to be 01 at the very edge where a high or low byte write lands, and then a quiet cycle has to follow. A directed sequence writes 01 and immediately writes a CRC byte, then idles, and checks the register after each edge. The random phase mixes control writes with back-to-back byte writes so that many further collisions occur, including ones while the block is switched off, and compares every edge against a bench model.

// File: rtl/lfsr_crc_pkg.sv
package lfsr_crc_pkg;

    typedef enum logic [1:0] {
        CTL_IDLE = 2'b00,
        CTL_STEP = 2'b01,
        CTL_RSVD = 2'b10,
        CTL_OFF  = 2'b11
    } ctl_mode_e;

    localparam logic [1:0] ADDR_LO  = 2'd0;
    localparam logic [1:0] ADDR_HI  = 2'd1;
    localparam logic [1:0] ADDR_CTL = 2'd2;

endpackage

// File: rtl/lfsr_unroll.sv
// Combinational chain of STEPS single-bit shift-register updates.
// din[STEPS-1] is consumed first.
module lfsr_unroll #(
    parameter int          W     = 16,
    parameter int          STEPS = 8,
    parameter logic [W-1:0] POLY = 16'h8005
) (
    input  logic [W-1:0]     state_in,
    input  logic [STEPS-1:0] din,
    output logic [W-1:0]     state_out
);

    logic [STEPS:0][W-1:0] chain;

    assign chain[0] = state_in;

    for (genvar i = 0; i < STEPS; i++) begin : g_step
        logic fb;
        assign fb           = chain[i][W-1] ^ din[STEPS-1-i];
        assign chain[i+1]   = {chain[i][W-2:0], 1'b0} ^ (fb ? POLY : '0);
    end

    assign state_out = chain[STEPS];

endmodule

// File: rtl/lfsr_ctrl_fsm.sv
// Control-field state machine: the field value is the machine state.
module lfsr_ctrl_fsm
    import lfsr_crc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ctl_wr,
    input  logic       data_wr,
    input  logic [1:0] ctl_wdata,
    output ctl_mode_e  mode,
    output logic       step_fire,
    output logic       gen_off
);

    ctl_mode_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (ctl_wr) begin
            state_d = ctl_mode_e'(ctl_wdata);            // ctrl_load
        end else begin
            unique case (state_q)
                CTL_STEP: state_d = data_wr ? CTL_STEP   // step_wait
                                            : CTL_IDLE;  // step_done
                CTL_IDLE, CTL_RSVD, CTL_OFF: state_d = state_q;
                default:  state_d = CTL_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= CTL_IDLE;
        else        state_q <= state_d;
    end

    // outputs
    always_comb begin
        step_fire = 1'b0;
        gen_off   = 1'b0;
        unique case (state_q)
            CTL_STEP: step_fire = !data_wr;
            CTL_OFF:  gen_off   = 1'b1;
            CTL_IDLE, CTL_RSVD: ;
            default:  ;
        endcase
    end

    assign mode = state_q;

    assert_step_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CTL_STEP && !ctl_wr && !data_wr) |=> (state_q == CTL_IDLE));

    assert_step_waits_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == CTL_STEP && data_wr) |=> (state_q == CTL_STEP));

endmodule

// File: rtl/lfsr_state_reg.sv
// Holds the shift register and selects among seed, CRC byte and random advance.
module lfsr_state_reg #(
    parameter int            BYTE_W = 8,
    parameter int            ROUNDS = 13,
    parameter logic [2*BYTE_W-1:0] POLY = 16'h8005,
    localparam int           W      = 2 * BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              seed_wr,
    input  logic              crc_wr,
    input  logic              step_fire,
    input  logic [BYTE_W-1:0] wdata,
    output logic [W-1:0]      state
);

    logic [W-1:0] state_q, state_d;
    logic [W-1:0] crc_next, rnd_next;

    lfsr_unroll #(.W(W), .STEPS(BYTE_W), .POLY(POLY)) u_crc_chain (
        .state_in  (state_q),
        .din       (wdata),
        .state_out (crc_next)
    );

    lfsr_unroll #(.W(W), .STEPS(ROUNDS), .POLY(POLY)) u_rnd_chain (
        .state_in  (state_q),
        .din       ('0),
        .state_out (rnd_next)
    );

    always_comb begin
        state_d = state_q;
        if (seed_wr)        state_d = {state_q[BYTE_W-1:0], wdata};
        else if (crc_wr)    state_d = crc_next;
        else if (step_fire) state_d = rnd_next;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign state = state_q;

    assert_seed_shift_R3: assert property (@(posedge clk) disable iff (!rst_n)
        seed_wr |=> (state_q == {$past(state_q[BYTE_W-1:0]), $past(wdata)}));

endmodule

// File: rtl/lfsr_crc_unit.sv
module lfsr_crc_unit
    import lfsr_crc_pkg::*;
#(
    parameter int   BYTE_W = 8,
    parameter int   ROUNDS = 13,
    parameter logic [15:0] POLY = 16'h8005
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_wr,
    input  logic [1:0]  bus_addr,
    input  logic [7:0]  bus_wdata,
    output logic [7:0]  bus_rdata
);

    logic [15:0] state;
    ctl_mode_e   mode;
    logic        step_fire, gen_off;
    logic        seed_wr, hi_wr, ctl_wr;

    assign seed_wr = bus_wr && (bus_addr == ADDR_LO);
    assign hi_wr   = bus_wr && (bus_addr == ADDR_HI);
    assign ctl_wr  = bus_wr && (bus_addr == ADDR_CTL);

    lfsr_ctrl_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl_wr    (ctl_wr),
        .data_wr   (seed_wr || hi_wr),
        .ctl_wdata (bus_wdata[1:0]),
        .mode      (mode),
        .step_fire (step_fire),
        .gen_off   (gen_off)
    );

    lfsr_state_reg #(.BYTE_W(BYTE_W), .ROUNDS(ROUNDS), .POLY(POLY)) u_state (
        .clk       (clk),
        .rst_n     (rst_n),
        .seed_wr   (seed_wr),
        .crc_wr    (hi_wr && !gen_off),
        .step_fire (step_fire),
        .wdata     (bus_wdata),
        .state     (state)
    );

    always_comb begin
        unique case (bus_addr)
            ADDR_LO:  bus_rdata = state[7:0];
            ADDR_HI:  bus_rdata = state[15:8];
            ADDR_CTL: bus_rdata = {6'b0, mode};
            default:  bus_rdata = 8'h00;
        endcase
    end

    assert_off_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CTL_OFF && !seed_wr) |=> $stable(state));

    assert_idle_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode == CTL_IDLE || mode == CTL_RSVD) && !seed_wr && !hi_wr) |=> $stable(state));

    assert_crc_first_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == CTL_STEP && hi_wr) |=> (mode == CTL_STEP));

endmodule

// File: tb/lfsr_crc_unit_test.sv
`timescale 1ns/1ps
module lfsr_crc_unit_test;

    logic       clk = 0;
    logic       rst_n = 0;
    logic       bus_wr = 0;
    logic [1:0] bus_addr = 0;
    logic [7:0] bus_wdata = 0;
    logic [7:0] bus_rdata;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    logic [15:0] m_st;
    logic [1:0]  m_ctl;

    always #2 clk = ~clk;

    lfsr_crc_unit uut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic [15:0] one_step(logic [15:0] s, logic b);
        logic fb;
        fb = s[15] ^ b;
        one_step = {s[14:0], 1'b0};
        if (fb) one_step = one_step ^ 16'h8005;
    endfunction

    function automatic logic [15:0] crc_byte(logic [15:0] s, logic [7:0] d);
        logic [15:0] r;
        r = s;
        for (int i = 7; i >= 0; i--) r = one_step(r, d[i]);
        return r;
    endfunction

    function automatic logic [15:0] rnd13(logic [15:0] s);
        logic [15:0] r;
        r = s;
        for (int i = 0; i < 13; i++) r = one_step(r, 1'b0);
        return r;
    endfunction

    task automatic model_tick(bit wr, logic [1:0] a, logic [7:0] d);
        bit dw;
        dw = wr && (a == 2'd0 || a == 2'd1);
        if (wr && a == 2'd0)                  m_st = {m_st[7:0], d};
        else if (wr && a == 2'd1 && m_ctl != 2'd3) m_st = crc_byte(m_st, d);
        else if (m_ctl == 2'd1 && !dw)        m_st = rnd13(m_st);
        if (wr && a == 2'd2)                  m_ctl = d[1:0];
        else if (m_ctl == 2'd1 && !dw)        m_ctl = 2'd0;
    endtask

    task automatic check(string req, logic [15:0] act, logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic read16(output logic [15:0] v);
        bus_addr = 2'd0; #0.2; v[7:0]  = bus_rdata;
        bus_addr = 2'd1; #0.2; v[15:8] = bus_rdata;
    endtask

    task automatic read_ctl(output logic [7:0] v);
        bus_addr = 2'd2; #0.2; v = bus_rdata;
    endtask

    task automatic cycle(bit wr, logic [1:0] a, logic [7:0] d);
        bus_wr = wr; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_wr = 0;
        model_tick(wr, a, d);
    endtask

    task automatic check_all(string req);
        logic [15:0] s;
        logic [7:0]  c;
        read16(s);
        read_ctl(c);
        check(req, s, m_st);
        check(req, {8'h00, c}, {14'd0, m_ctl});
    endtask

    initial begin
        #(200000 * 4);
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        logic [15:0] s;
        logic [7:0]  c;
        void'($urandom(32'd4242));
        m_st = 16'h0000; m_ctl = 2'd0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;

        // R1 reset state
        read16(s); check("R1 state", s, 16'h0000);
        read_ctl(c); check("R1 ctrl", {8'h0, c}, 16'h0000);
        // R2 unused address reads zero
        bus_addr = 2'd3; #0.2; check("R2 addr3", {8'h0, bus_rdata}, 16'h0000);

        // R3 seeding by two shifting writes
        cycle(1, 2'd0, 8'hA5); check_all("R3 first");
        cycle(1, 2'd0, 8'h3C);
        read16(s); check("R3 seed", s, 16'hA53C);
        check_all("R2 map");

        // R5 known vector, back-to-back bytes (R4)
        cycle(1, 2'd0, 8'hFF); cycle(1, 2'd0, 8'hFF);
        cycle(1, 2'd1, 8'h03); cycle(1, 2'd1, 8'h41);
        cycle(1, 2'd1, 8'h42); cycle(1, 2'd1, 8'h43);
        read16(s); check("R5 vector", s, 16'hB4BC);
        check_all("R4 model");

        // R6 random advance and auto clear
        cycle(1, 2'd0, 8'h12); cycle(1, 2'd0, 8'h34);
        cycle(1, 2'd2, 8'h01);
        read_ctl(c); check("R6 pending", {8'h0, c}, 16'h0001);
        cycle(0, 2'd0, 8'h00);
        read16(s); check("R6 step13", s, rnd13(16'h1234));
        read_ctl(c); check("R6 clear", {8'h0, c}, 16'h0000);

        // R9 collision: CRC byte wins, step follows
        cycle(1, 2'd2, 8'h01);
        cycle(1, 2'd1, 8'h5A);
        read16(s); check("R9 crc first", s, crc_byte(rnd13(16'h1234), 8'h5A));
        read_ctl(c); check("R9 still pending", {8'h0, c}, 16'h0001);
        cycle(0, 2'd0, 8'h00);
        read16(s); check("R9 deferred step", s, rnd13(crc_byte(rnd13(16'h1234), 8'h5A)));
        check_all("R9 model");

        // R7 off mode: CRC ignored, seeding accepted
        cycle(1, 2'd2, 8'h03);
        cycle(1, 2'd1, 8'hC3); cycle(1, 2'd1, 8'h11); cycle(0, 2'd0, 8'h00);
        check_all("R7 crc ignored");
        cycle(1, 2'd0, 8'h77);
        check_all("R7 seed while off");

        // R8 reserved and idle modes hold
        cycle(1, 2'd2, 8'h02);
        cycle(0, 2'd0, 8'h00); cycle(0, 2'd0, 8'h00);
        check_all("R8 reserved hold");
        cycle(1, 2'd2, 8'h00); cycle(0, 2'd0, 8'h00);
        check_all("R8 idle hold");

        // random mix, checked against the model each edge
        for (int n = 0; n < 3000; n++) begin
            int op;
            op = $urandom % 8;
            case (op)
                0, 1, 2: cycle(1, 2'd1, 8'($urandom));
                3:       cycle(1, 2'd0, 8'($urandom));
                4:       cycle(1, 2'd2, 8'h01);
                5:       cycle(1, 2'd2, 8'($urandom % 4));
                6:       cycle(0, 2'd0, 8'h00);
                default: cycle(1, 2'd3, 8'($urandom));
            endcase
            check_all("R4 R6 R7 R9 random");
        end

        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule